// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This block keeps wall-clock time and calendar date in packed BCD. It holds seconds, minutes, hours, day of month, month, weekday and a two-digit year. A prescaler counts pulses of an external reference enable (nominally 32.768 kHz, one pulse per reference period) and produces a one-second advance. The hours field works in either 24-hour or 12-hour form, chosen by its own top bit. The date rolls over at the true end of each month, with February 29 in leap years.

A host loads or reads any register through a flat parallel port made of an address, write data, a write strobe and combinational read data. A halt bit in the seconds register freezes both the prescaler and the counters, which lets software set the time and then release it. Writing the seconds register also restarts the fractional second, so the next advance comes one full second after the write.

Top module: `rtc_bcd_core`

## Requirements
- R1: Address map: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 weekday, 6 year. After reset these registers read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00. Address 7 always reads 0x00, and writes to it change nothing.
- R2: The seconds field (bits 6:0, BCD 00–59) advances once per REF_DIV reference pulses. Its 59→00 step advances the minutes.
- R3: The minutes field (bits 6:0, BCD 00–59) steps 59→00 when the seconds wrap, and that step advances the hours.
- R4: When hours bit 7 is 0 (24-hour form), bits 5:0 hold BCD 00–23. The step 23→00 advances the day of month and the weekday.
- R5: When hours bit 7 is 1 (12-hour form), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 01–12. Stepping 11→12 toggles PM, and stepping 12→01 does not. Going from 11 PM to 12 AM advances the day.
- R6: April, June, September and November end after day 30. All other months except February end after day 31.
- R7: February ends after day 29 when the year is a multiple of four (year 00 included), and after day 28 otherwise.
- R8: Month steps 12→01 at the end of December and advances the year. The year steps 99→00.
- R9: The weekday counts 1..7 and wraps 7→1 on each day advance.
- R10: While seconds bit 7 (halt) is 1, no register advances and the prescaler holds its count. Clearing the bit lets counting resume.
- R11: A write lands on the next clock edge and reads back unchanged in its stored bits. Writing seconds restarts the prescaler, so the next advance needs a full REF_DIV pulses. No register advances in a cycle that carries a write.
- R12: `sec_tick` is high for exactly one clock per one-second advance and stays low while halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| sec_tick | output | 1 | One-second advance pulse |

## Verification
The bench builds the core with REF_DIV = 4, so one simulated second takes four reference pulses instead of 32768. That brings every rollover within reach in a short run: minute, hour, day, month-end, leap February and century wrap in both hour formats. It also makes the restart of the fractional second after a seconds write visible cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef logic [7:0] bcd8_t;

    typedef enum logic [2:0] {
        RA_SEC   = 3'd0,
        RA_MIN   = 3'd1,
        RA_HOUR  = 3'd2,
        RA_DATE  = 3'd3,
        RA_MONTH = 3'd4,
        RA_WDAY  = 3'd5,
        RA_YEAR  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hr;
    } clk_state_t;

    typedef struct packed {
        bcd8_t date;
        bcd8_t mon;
        bcd8_t wday;
        bcd8_t yr;
    } cal_state_t;

    // Add one to a two-digit packed BCD value (no wrap above 99 handled here).
    function automatic bcd8_t bcd_inc(bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(bcd8_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic is_leap(bcd8_t yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd8_t month_last_day(bcd8_t mon, bcd8_t yr);
        bcd8_t r;
        case (mon)
            8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned REF_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic halt,
    input  logic restart,
    output logic sec_tick
);
    localparam int unsigned CW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        sec_tick = ref_tick && !halt && (cnt_q == LAST);
        if (restart) begin
            cnt_d = '0;
        end else if (ref_tick && !halt) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rtc_clock_regs.sv
module rtc_clock_regs
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hr,
    input  logic [7:0] wdata,
    output bcd8_t      sec_q,
    output bcd8_t      min_q,
    output bcd8_t      hr_q,
    output logic       day_roll
);
    clk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        day_roll = 1'b0;
        if (adv) begin
            if (st_q.sec[6:0] == 7'h59) begin
                st_d.sec = {st_q.sec[7], 7'h00};
                if (st_q.min[6:0] == 7'h59) begin
                    st_d.min = 8'h00;
                    if (st_q.hr[7]) begin
                        // 12-hour form: bit 5 is the PM flag
                        if (st_q.hr[4:0] == 5'h11) begin
                            st_d.hr  = {2'b10, ~st_q.hr[5], 5'h12};
                            day_roll = st_q.hr[5];
                        end else if (st_q.hr[4:0] == 5'h12) begin
                            st_d.hr = {st_q.hr[7:5], 5'h01};
                        end else begin
                            st_d.hr = {st_q.hr[7:5], 5'(bcd_inc({3'b000, st_q.hr[4:0]}))};
                        end
                    end else begin
                        if (st_q.hr[5:0] == 6'h23) begin
                            st_d.hr  = 8'h00;
                            day_roll = 1'b1;
                        end else begin
                            st_d.hr = {2'b00, 6'(bcd_inc({2'b00, st_q.hr[5:0]}))};
                        end
                    end
                end else begin
                    st_d.min = {1'b0, 7'(bcd_inc({1'b0, st_q.min[6:0]}))};
                end
            end else begin
                st_d.sec = {st_q.sec[7], 7'(bcd_inc({1'b0, st_q.sec[6:0]}))};
            end
        end
        if (wr_sec) st_d.sec = wdata;
        if (wr_min) st_d.min = {1'b0, wdata[6:0]};
        if (wr_hr)  st_d.hr  = {wdata[7], 1'b0, wdata[5:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sec: 8'h00, min: 8'h00, hr: 8'h00};
        else        st_q <= st_d;
    end

    assign sec_q = st_q.sec;
    assign min_q = st_q.min;
    assign hr_q  = st_q.hr;

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       wr_date,
    input  logic       wr_mon,
    input  logic       wr_wday,
    input  logic       wr_yr,
    input  logic [7:0] wdata,
    output bcd8_t      date_q,
    output bcd8_t      mon_q,
    output bcd8_t      wday_q,
    output bcd8_t      yr_q
);
    cal_state_t st_d, st_q;
    bcd8_t      last_day;

    always_comb begin
        st_d     = st_q;
        last_day = month_last_day(st_q.mon, st_q.yr);
        if (adv) begin
            st_d.wday = (st_q.wday[2:0] >= 3'd7) ? 8'h01 : {5'b0, st_q.wday[2:0] + 3'd1};
            if (st_q.date >= last_day) begin
                st_d.date = 8'h01;
                if (st_q.mon >= 8'h12) begin
                    st_d.mon = 8'h01;
                    st_d.yr  = (st_q.yr >= 8'h99) ? 8'h00 : bcd_inc(st_q.yr);
                end else begin
                    st_d.mon = bcd_inc(st_q.mon);
                end
            end else begin
                st_d.date = bcd_inc(st_q.date);
            end
        end
        if (wr_date) st_d.date = {2'b00, wdata[5:0]};
        if (wr_mon)  st_d.mon  = {3'b000, wdata[4:0]};
        if (wr_wday) st_d.wday = {5'b00000, wdata[2:0]};
        if (wr_yr)   st_d.yr   = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{date: 8'h01, mon: 8'h01, wday: 8'h01, yr: 8'h00};
        else        st_q <= st_d;
    end

    assign date_q = st_q.date;
    assign mon_q  = st_q.mon;
    assign wday_q = st_q.wday;
    assign yr_q   = st_q.yr;

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int unsigned REF_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       sec_tick
);
    localparam int unsigned NREG = 8;

    logic [NREG-1:0] wr_sel;
    bcd8_t           sec_q, min_q, hr_q, date_q, mon_q, wday_q, yr_q;
    logic            day_roll;
    logic            adv_time;

    for (genvar g = 0; g < NREG; g++) begin : g_wdec
        assign wr_sel[g] = wr_en && (addr == 3'(g));
    end

    assign adv_time = sec_tick && !wr_en;

    rtc_prescaler #(.REF_DIV(REF_DIV)) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .halt     (sec_q[7]),
        .restart  (wr_sel[RA_SEC]),
        .sec_tick (sec_tick)
    );

    rtc_clock_regs i_clk_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv_time),
        .wr_sec   (wr_sel[RA_SEC]),
        .wr_min   (wr_sel[RA_MIN]),
        .wr_hr    (wr_sel[RA_HOUR]),
        .wdata    (wdata),
        .sec_q    (sec_q),
        .min_q    (min_q),
        .hr_q     (hr_q),
        .day_roll (day_roll)
    );

    rtc_calendar_regs i_cal_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (day_roll),
        .wr_date (wr_sel[RA_DATE]),
        .wr_mon  (wr_sel[RA_MONTH]),
        .wr_wday (wr_sel[RA_WDAY]),
        .wr_yr   (wr_sel[RA_YEAR]),
        .wdata   (wdata),
        .date_q  (date_q),
        .mon_q   (mon_q),
        .wday_q  (wday_q),
        .yr_q    (yr_q)
    );

    always_comb begin
        case (reg_addr_e'(addr))
            RA_SEC:   rdata = sec_q;
            RA_MIN:   rdata = min_q;
            RA_HOUR:  rdata = hr_q;
            RA_DATE:  rdata = date_q;
            RA_MONTH: rdata = mon_q;
            RA_WDAY:  rdata = wday_q;
            RA_YEAR:  rdata = yr_q;
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       sec_tick,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hr_q,
    input logic [7:0] wday_q,
    input logic [7:0] date_q,
    input logic [7:0] mon_q,
    input logic [7:0] yr_q
);
    logic [55:0] all_regs;
    logic        hour_end;
    assign all_regs = {sec_q, min_q, hr_q, wday_q, date_q, mon_q, yr_q};
    assign hour_end = sec_tick && !wr_en && (sec_q[6:0] == 7'h59) && (min_q[6:0] == 7'h59);

    assert_halt_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q[7] |-> !sec_tick);

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en) |=> $stable(all_regs));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !wr_en) |=> $stable(all_regs));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00) && (min_q != $past(min_q)));

    assert_hr24_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_end && !hr_q[7] && hr_q[5:0] == 6'h23) |=> (hr_q == 8'h00) && (wday_q != $past(wday_q)));

    assert_hr12_pm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_end && hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[4:0] == 5'h12) && (hr_q[5] != $past(hr_q[5])));

    assert_tick_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

endmodule

bind rtc_bcd_core rtc_bcd_checker i_rtc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sec_tick (sec_tick),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hr_q     (hr_q),
    .wday_q   (wday_q),
    .date_q   (date_q),
    .mon_q    (mon_q),
    .yr_q     (yr_q)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sec_tick;

    int checks = 0;
    int errors = 0;

    // reference model, plain binary
    int m_sec, m_min, m_hr, m_date, m_mon, m_wday, m_yr;
    bit m_halt, m_12;

    rtc_bcd_core #(.REF_DIV(DIV)) i_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int month_days(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_reg(int a);
        int h;
        case (a)
            0: return {m_halt, 7'(to_bcd(m_sec))};
            1: return to_bcd(m_min);
            2: begin
                if (m_12) begin
                    h = (m_hr % 12 == 0) ? 12 : m_hr % 12;
                    return {2'b10, (m_hr >= 12) ? 1'b1 : 1'b0, 5'(to_bcd(h))};
                end
                return to_bcd(m_hr);
            end
            3: return to_bcd(m_date);
            4: return to_bcd(m_mon);
            5: return to_bcd(m_wday);
            6: return to_bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        if (m_halt) return;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        m_date++;
        if (m_date <= month_days(m_mon, m_yr)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_yr = (m_yr + 1) % 100;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = 3'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        @(negedge clk);
        addr = 3'(a);
        #1 d = rdata;
    endtask

    task automatic check_all(string tag);
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            check(tag, $sformatf("reg%0d", a), d, exp_reg(a));
        end
    endtask

    task automatic load_model();
        for (int a = 6; a >= 0; a--) wr(a, exp_reg(a));
    endtask

    // drive ref_tick for k cycles, return number of sec_tick pulses seen
    task automatic ref_cycles(int k, output int ticks);
        ticks = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            #1 if (sec_tick) ticks++;
        end
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic run_secs(int n, string tag);
        int t;
        ref_cycles(n * DIV, t);
        for (int i = 0; i < n; i++) model_step();
        check(tag, "sec_tick count (R12)", t, m_halt ? 0 : n);
    endtask

    task automatic set_model(int yr, int mon, int date, int wday, int hr, int mn, int sc, bit h12, bit halt);
        m_yr = yr; m_mon = mon; m_date = date; m_wday = wday;
        m_hr = hr; m_min = mn; m_sec = sc; m_12 = h12; m_halt = halt;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        set_model(0, 1, 1, 1, 0, 0, 0, 1'b0, 1'b0);
        check_all("R1");

        // R1 unused address
        wr(7, 8'hA5);
        rd(7, d);
        check("R1", "addr7 read", d, 0);
        check_all("R1");

        // R11 write readback
        wr(1, 8'h37);
        rd(1, d);
        check("R11", "minutes readback", d, 8'h37);
        wr(1, 8'h00);

        // R2 and R3 carries
        set_model(21, 5, 10, 3, 10, 59, 58, 1'b0, 1'b0);
        load_model();
        run_secs(1, "R2");
        check_all("R2");
        run_secs(1, "R3");
        check_all("R3");

        // R4 R8 R9 century wrap in 24-hour form
        set_model(99, 12, 31, 7, 23, 59, 59, 1'b0, 1'b0);
        load_model();
        run_secs(1, "R4");
        check_all("R4/R8/R9");

        // R6 thirty-day month, and a 31-day month
        set_model(23, 4, 30, 2, 23, 59, 59, 1'b0, 1'b0);
        load_model();
        run_secs(1, "R6");
        check_all("R6");
        set_model(23, 5, 30, 2, 23, 59, 59, 1'b0, 1'b0);
        load_model();
        run_secs(1, "R6");
        check_all("R6");

        // R7 leap handling
        set_model(23, 2, 28, 1, 23, 59, 59, 1'b0, 1'b0);
        load_model(); run_secs(1, "R7"); check_all("R7");
        set_model(24, 2, 28, 1, 23, 59, 59, 1'b0, 1'b0);
        load_model(); run_secs(1, "R7"); check_all("R7");
        set_model(24, 2, 29, 1, 23, 59, 59, 1'b0, 1'b0);
        load_model(); run_secs(1, "R7"); check_all("R7");
        set_model(0, 2, 28, 1, 23, 59, 59, 1'b0, 1'b0);
        load_model(); run_secs(1, "R7"); check_all("R7");

        // R5 12-hour form
        set_model(22, 6, 15, 4, 11, 59, 59, 1'b1, 1'b0);
        load_model(); run_secs(1, "R5"); check_all("R5");
        check("R5", "11AM->12PM", exp_reg(2), 8'hB2);
        set_model(22, 6, 15, 4, 12, 59, 59, 1'b1, 1'b0);
        load_model(); run_secs(1, "R5"); check_all("R5");
        set_model(22, 6, 15, 4, 23, 59, 59, 1'b1, 1'b0);
        load_model(); run_secs(1, "R5"); check_all("R5");

        // R10 halt
        set_model(22, 6, 15, 4, 8, 30, 20, 1'b0, 1'b1);
        load_model();
        run_secs(5, "R10");
        check_all("R10");
        m_halt = 1'b0;
        wr(0, exp_reg(0));
        run_secs(3, "R10");
        check_all("R10");

        // R11 write restarts the fractional second
        set_model(22, 6, 15, 4, 8, 30, 20, 1'b0, 1'b0);
        load_model();
        ref_cycles(2, t);
        wr(0, exp_reg(0));
        ref_cycles(DIV - 1, t);
        check("R11", "ticks before full second", t, 0);
        rd(0, d);
        check("R11", "seconds held", d, exp_reg(0));
        ref_cycles(1, t);
        model_step();
        check("R11", "tick after full second", t, 1);
        check_all("R11");

        // R2 R3 R4 R5 random sweep
        for (int it = 0; it < 40; it++) begin
            int y, mo;
            y  = $urandom % 100;
            mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
            set_model(y, mo,
                      ($urandom % 2) ? month_days(mo, y) : 1 + $urandom % month_days(mo, y),
                      1 + $urandom % 7,
                      ($urandom % 2) ? 23 : (($urandom % 2) ? 11 : $urandom % 24),
                      ($urandom % 2) ? 59 : $urandom % 60,
                      40 + $urandom % 20,
                      1'($urandom % 2), 1'b0);
            load_model();
            run_secs(1 + $urandom % 70, "R2");
            check_all("R2/R3/R4/R5");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule